// File: doc/BRIEF.md
# Reset Control Register

This block is the one-byte, I/O-mapped reset control register of a host bridge. Software writes the byte to ask for a system reset. A reset starts only when the trigger bit goes from clear to set. The block compares the incoming byte with the value it already holds, then stores the new byte. Writing the trigger bit again while it is still set has no effect.

Every trigger produces a CPU reset pulse of a fixed number of clock cycles. When the triggering write also sets the hard-reset bit, the block issues a one-cycle write strobe toward the host bridge's boot-region attribute register. The strobe carries that register's offset and its restore value, so the boot region points back at the boot ROM. A read at the decoded address returns the stored byte. Accesses at any other I/O address do nothing and return no data.

Top module: `rstctl_reg`

## Requirements
- R1: After reset the stored byte is 0x00, the CPU reset output is low and the attribute strobe is low.
- R2: A write at I/O address 0xCF9 stores the full byte. A read at that address raises the read-acknowledge and returns the last stored byte.
- R3: A write at any other address changes nothing and starts no reset. A read at any other address keeps the acknowledge low and returns 0x00.
- R4: A write at 0xCF9 with bit 2 set, while the stored byte has bit 2 clear, raises the CPU reset output in the cycle after the write.
- R5: A write with bit 2 set while the stored byte already has bit 2 set starts no reset. A write with bit 2 clear never starts one.
- R6: The CPU reset output stays high for exactly PULSE_CYC consecutive cycles (default 8), then falls.
- R7: If bit 1 is set in a triggering write, the attribute strobe is high for exactly one cycle, in the cycle after the write, with index 0x59 and data 0x0F.
- R8: A trigger with bit 1 clear, or bit 1 written without a trigger, leaves the attribute strobe low.
- R9: A new trigger during a running pulse (bit 2 written clear, then set again) reloads the pulse. The output then stays high for PULSE_CYC cycles counted from the new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write request |
| io_rd | input | 1 | I/O read request |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0x00 when not addressed) |
| io_rack | output | 1 | Read acknowledge at the decoded address |
| cpu_reset_o | output | 1 | CPU reset pulse |
| attr_wr_o | output | 1 | One-cycle write strobe to the attribute register |
| attr_idx_o | output | 8 | Attribute register offset sent with the strobe |
| attr_data_o | output | 8 | Attribute restore value sent with the strobe |

## Verification
On every cycle, the assertions check the following:
- A clear-to-set write raises the CPU reset in the next cycle.
- The output cannot rise without such a write.
- The pulse counter stays in range and the pulse ends only when the count runs out.
- The attribute strobe lasts one cycle and always comes with a CPU reset.
- The stored byte tracks each decoded write.

Only the bench scenarios can show the following:
- The exact pulse width and the reload on retrigger.
- That misses at other addresses leave the stored byte untouched.
- That the combined trigger and hard-bit decisions are right for every pair of previous and new bytes.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int TRIG_BIT = 2;
    localparam int HARD_BIT = 1;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t ctl;
    } ctl_state_t;

    typedef struct packed {
        logic strobe;
    } strobe_state_t;

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode #(
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    PORT_ADDR = 16'hCF9
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic sel;

    always_comb begin
        sel    = (io_addr == PORT_ADDR);
        wr_hit = sel && io_wr;
        rd_hit = sel && io_rd;
    end

endmodule

// File: rtl/rstctl_edge.sv
module rstctl_edge
    import rstctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  byte_t wdata,
    output byte_t ctl_q,
    output logic  trig,
    output logic  hard
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        trig = 1'b0;
        hard = 1'b0;
        if (wr_hit) begin
            // compare against the old contents before storing the new byte
            trig     = wdata[TRIG_BIT] && !st_q.ctl[TRIG_BIT];
            hard     = trig && wdata[HARD_BIT];
            st_d.ctl = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_q = st_q.ctl;

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ctl_q == $past(wdata));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctl_q));

endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
    parameter int unsigned PULSE_CYC = 8,
    localparam int unsigned CNT_W    = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig)
            st_d.cnt = CNT_W'(PULSE_CYC);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(PULSE_CYC));

    assert_fall_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(st_q.cnt) == CNT_W'(1));

endmodule

// File: rtl/rstctl_reg.sv
module rstctl_reg
    import rstctl_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'hCF9,
    parameter int unsigned       PULSE_CYC   = 8,
    parameter logic [7:0]        ATTR_OFFSET = 8'h59,
    parameter logic [7:0]        ATTR_VALUE  = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rack,
    output logic              cpu_reset_o,
    output logic              attr_wr_o,
    output logic [7:0]        attr_idx_o,
    output logic [7:0]        attr_data_o
);

    logic  wr_hit, rd_hit, trig, hard;
    byte_t ctl_q;

    rstctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    rstctl_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (io_wdata),
        .ctl_q  (ctl_q),
        .trig   (trig),
        .hard   (hard)
    );

    rstctl_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .busy_o (cpu_reset_o)
    );

    strobe_state_t sb_d, sb_q;

    always_comb begin
        sb_d        = sb_q;
        sb_d.strobe = hard;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    always_comb begin
        io_rack     = rd_hit;
        io_rdata    = rd_hit ? ctl_q : 8'h00;
        attr_wr_o   = sb_q.strobe;
        attr_idx_o  = ATTR_OFFSET;
        attr_data_o = ATTR_VALUE;
    end

    assert_trig_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && io_wdata[TRIG_BIT] && !ctl_q[TRIG_BIT]) |=> cpu_reset_o);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_reset_o && !(wr_hit && io_wdata[TRIG_BIT] && !ctl_q[TRIG_BIT]))
        |=> !cpu_reset_o);

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        attr_wr_o |=> !attr_wr_o);

    assert_strobe_with_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        attr_wr_o |-> cpu_reset_o);

endmodule

// File: tb/test_rstctl_reg.sv
module test_rstctl_reg;

    localparam int unsigned PULSE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rack;
    logic        cpu_reset_o;
    logic        attr_wr_o;
    logic [7:0]  attr_idx_o;
    logic [7:0]  attr_data_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    rstctl_reg #(.PULSE_CYC(PULSE)) i_rstctl_reg (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rack(io_rack),
        .cpu_reset_o(cpu_reset_o), .attr_wr_o(attr_wr_o),
        .attr_idx_o(attr_idx_o), .attr_data_o(attr_data_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic ack);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; ack = io_rack;
        io_rd = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < PULSE + 4 && cpu_reset_o; k++) @(negedge clk);
    endtask

    task automatic width(output int n);
        n = 0;
        while (cpu_reset_o && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                vectors++;
                $display("FAIL watchdog: actual %0d expected below 190000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] rd;
        logic       ack;
        int         n;
        logic [7:0] v;
        logic       exp_t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cpu_reset", cpu_reset_o, 0);
        check("R1 strobe", attr_wr_o, 0);
        io_read(16'hCF9, rd, ack);
        check("R1 stored", rd, 8'h00);
        check("R2 ack", ack, 1);

        // R6 pulse width, R4 timing
        io_write(16'hCF9, 8'h04);
        check("R4 rise after write", cpu_reset_o, 1);
        check("R8 soft no strobe", attr_wr_o, 0);
        width(n);
        check("R6 width", n, PULSE);

        // R5 rewrite with bit 2 still set
        io_write(16'hCF9, 8'h06);
        check("R5 no retrigger", cpu_reset_o, 0);
        check("R8 hard bit without trigger", attr_wr_o, 0);

        // R7 hard reset strobe
        io_write(16'hCF9, 8'h00);
        io_write(16'hCF9, 8'h06);
        check("R7 strobe", attr_wr_o, 1);
        check("R7 index", attr_idx_o, 8'h59);
        check("R7 data", attr_data_o, 8'h0F);
        check("R4 hard asserts reset", cpu_reset_o, 1);
        @(negedge clk);
        check("R7 strobe one cycle", attr_wr_o, 0);
        drain();

        // R9 retrigger during pulse
        io_write(16'hCF9, 8'h00);
        io_write(16'hCF9, 8'h04);
        repeat (3) @(negedge clk);
        io_write(16'hCF9, 8'h00);
        io_write(16'hCF9, 8'h04);
        width(n);
        check("R9 reload width", n, PULSE);

        // R3 other addresses ignored
        io_write(16'hCF9, 8'h00);
        drain();
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            a = 16'hCF9 ^ (16'h1 << i);
            io_write(a, 8'hFF);
            check("R3 miss no reset", cpu_reset_o, 0);
            check("R3 miss no strobe", attr_wr_o, 0);
            io_read(a, rd, ack);
            check("R3 miss rdata", rd, 8'h00);
            check("R3 miss ack", ack, 0);
            io_read(16'hCF9, rd, ack);
            check("R3 stored unchanged", rd, 8'h00);
        end

        // Sweep: every previous byte against 16 new bytes (R2 R4 R5 R7 R8)
        for (int p = 0; p < 256; p++) begin
            for (int j = 0; j < 16; j++) begin
                v = {4'(p + j), 4'(j)};
                io_write(16'hCF9, 8'(p));
                drain();
                io_write(16'hCF9, v);
                exp_t = v[2] & ~p[2];
                check("R4/R5 trigger", cpu_reset_o, exp_t);
                check("R7/R8 strobe", attr_wr_o, exp_t & v[1]);
                io_read(16'hCF9, rd, ack);
                check("R2 readback", rd, v);
                drain();
            end
        end

        finish_run();
    end

endmodule